// File: doc/BRIEF.md
# Windowed Majority Lock Detector

This block watches a one-bit serial stream and cuts it into back-to-back, non-overlapping frames of three bits. The first frame starts with the first clock edge after reset is released. Each frame is judged by majority vote. If the frame holds two or three ones, the detector raises its `locked` output and stays there. From then on the stream has no effect until a synchronous reset.

A small phase output shows which slot of the current frame the next sampled bit will fill. Logic further on can use it to line its own framing up with the detector. The frame length is a parameter. The majority threshold is derived from it as more than half of the frame.

Top module: `wlock_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, `locked` reads 0 and `phase` reads 0 after that edge.
- R2: While unlocked, `phase` steps 0, 1, 2, 0, ... by one on every rising edge, and never reaches 3 or more.
- R3: On the edge that samples the third bit of a frame holding two or three ones, `locked` becomes 1.
- R4: `locked` stays 0 on the edges that sample the first and second bits of a frame, even when both of those bits are 1.
- R5: A frame with zero or one ones leaves `locked` at 0 and carries none of its ones into the next frame. For example, frames 001 then 100 do not lock.
- R6: Frames are aligned to reset and do not slide. For example, the stream 0,1,1,0,0,0 (frames 011 and 000) locks at its third bit, and the stream 0,0,1,1,0,0 (frames 001 and 100) never locks.
- R7: Once `locked` is 1 it stays 1 and `phase` stays 0 whatever `din` does, until reset.
- R8: Reset leaves the locked state. The first frame after reset begins with the first edge at which `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, sampled on each rising edge |
| locked | output | 1 | High once a majority frame has been seen |
| phase | output | 2 | Slot (0..2) of the next bit in the current frame |

## Verification
Both outputs come straight from registers. Each sampled bit therefore shows its effect on `phase` and `locked` just after the same rising edge that captured it, with no extra latency. The bench drives `din` and `rst` at the falling edge. It samples one nanosecond after the following rising edge and compares both outputs against a reference frame model that is advanced by that same edge. Directed frames cover early double ones, carry-over of ones between frames, frame alignment, and input activity while locked. Biased random traffic with interleaved resets covers the rest.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

    // default frame length in bits
    localparam int unsigned DEF_FRAME_LEN = 3;

    typedef enum logic {
        ST_SCAN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;

    // width needed to hold slot indices 0..n-1
    function automatic int unsigned slot_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // width needed to hold a count 0..n
    function automatic int unsigned count_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

    // smallest count that forms a strict majority of n
    function automatic int unsigned majority_of(input int unsigned n);
        return n / 2 + 1;
    endfunction

endpackage

// File: rtl/wlock_slot_ctr.sv
module wlock_slot_ctr
    import wlock_pkg::*;
#(
    parameter int unsigned FRAME_LEN = DEF_FRAME_LEN,
    localparam int unsigned SLOT_W   = slot_width(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_end
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

    assign frame_end = (slot == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (!run) begin
            slot <= '0;
        end else if (frame_end) begin
            slot <= '0;
        end else begin
            slot <= slot + SLOT_W'(1);
        end
    end
endmodule

// File: rtl/wlock_ones_acc.sv
module wlock_ones_acc
    import wlock_pkg::*;
#(
    parameter int unsigned FRAME_LEN = DEF_FRAME_LEN,
    localparam int unsigned CNT_W    = count_width(FRAME_LEN),
    localparam int unsigned NEED     = majority_of(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             frame_end,
    input  logic             bit_in,
    output logic [CNT_W-1:0] ones_cnt,
    output logic             frame_pass
);
    logic [CNT_W-1:0] total;

    assign total      = ones_cnt + CNT_W'(bit_in);
    assign frame_pass = run && frame_end && (total >= CNT_W'(NEED));

    always_ff @(posedge clk) begin
        if (rst || !run || frame_end) begin
            ones_cnt <= '0;
        end else begin
            ones_cnt <= total;
        end
    end
endmodule

// File: rtl/wlock_latch_ctrl.sv
module wlock_latch_ctrl
    import wlock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_pass,
    output logic scanning,
    output logic locked
);
    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:   if (frame_pass) state_d = ST_LOCKED;
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SCAN;
        else     state_q <= state_d;
    end

    assign scanning = (state_q == ST_SCAN);
    assign locked   = (state_q == ST_LOCKED);
endmodule

// File: rtl/wlock_detector.sv
module wlock_detector
    import wlock_pkg::*;
#(
    parameter int unsigned FRAME_LEN = DEF_FRAME_LEN,
    localparam int unsigned SLOT_W   = slot_width(FRAME_LEN),
    localparam int unsigned CNT_W    = count_width(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    output logic              locked,
    output logic [SLOT_W-1:0] phase
);
    logic             scanning;
    logic             frame_end;
    logic             frame_pass;
    logic [CNT_W-1:0] ones_cnt;

    wlock_slot_ctr #(.FRAME_LEN(FRAME_LEN)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .run       (scanning),
        .slot      (phase),
        .frame_end (frame_end)
    );

    wlock_ones_acc #(.FRAME_LEN(FRAME_LEN)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .run        (scanning),
        .frame_end  (frame_end),
        .bit_in     (din),
        .ones_cnt   (ones_cnt),
        .frame_pass (frame_pass)
    );

    wlock_latch_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_pass (frame_pass),
        .scanning   (scanning),
        .locked     (locked)
    );
endmodule

// File: rtl/wlock_detector_chk.sv
module wlock_detector_chk
    import wlock_pkg::*;
#(
    parameter int unsigned FRAME_LEN = DEF_FRAME_LEN,
    localparam int unsigned SLOT_W   = slot_width(FRAME_LEN),
    localparam int unsigned CNT_W    = count_width(FRAME_LEN)
) (
    input logic              clk,
    input logic              rst,
    input logic              locked,
    input logic [SLOT_W-1:0] phase,
    input logic [CNT_W-1:0]  ones_cnt
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!locked && phase == '0)); // R1

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST); // R2

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!locked && phase != LAST) |=> (phase == $past(phase) + SLOT_W'(1))); // R2

    AST_NO_EARLY_LOCK: assert property (@(posedge clk) disable iff (rst)
        (!locked && phase != LAST) |=> !locked); // R4

    AST_LOCK_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(phase) == LAST)); // R3

    AST_FRAME_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (!locked && phase == LAST) |=> (ones_cnt == '0 && phase == '0)); // R5

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && phase == '0)); // R7
endmodule

bind wlock_detector wlock_detector_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .locked   (locked),
    .phase    (phase),
    .ones_cnt (ones_cnt)
);

// File: tb/wlock_detector_tb_top.sv
`timescale 1ns/1ps
module wlock_detector_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       locked;
    logic [1:0] phase;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference frame model
    int m_slot = 0;
    int m_ones = 0;
    bit m_lock = 1'b0;

    always #4 clk = ~clk;

    wlock_detector dut_i (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .locked (locked),
        .phase  (phase)
    );

    function automatic void model_edge(input bit r, input bit b);
        if (r) begin
            m_slot = 0; m_ones = 0; m_lock = 1'b0;
        end else if (!m_lock) begin
            if (m_slot == 2) begin
                if (m_ones + int'(b) >= 2) m_lock = 1'b1;
                m_ones = 0; m_slot = 0;
            end else begin
                m_ones += int'(b);
                m_slot += 1;
            end
        end
    endfunction

    task automatic check(input string req);
        n_vec++;
        if (locked !== m_lock || phase !== 2'(m_slot)) begin
            n_fail++;
            $display("FAIL %s: locked=%0b phase=%0d expected locked=%0b phase=%0d",
                     req, locked, phase, m_lock, m_slot);
        end
    endtask

    // drive one cycle at the falling edge, sample just after the rising edge
    task automatic step(input bit r, input bit b, input string req);
        @(negedge clk);
        rst = r; din = b;
        @(posedge clk);
        model_edge(r, b);
        #1;
        check(req);
    endtask

    task automatic do_reset(input string req);
        step(1'b1, 1'b0, req);
        step(1'b1, 1'b1, req);
    endtask

    task automatic bits3(input bit a, input bit b, input bit c, input string req);
        step(1'b0, a, req);
        step(1'b0, b, req);
        step(1'b0, c, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: locked=%0b phase=%0d expected run to end", locked, phase);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));

        do_reset("R1 reset state");

        // R2: phase walk without ones
        bits3(1'b0, 1'b0, 1'b0, "R2 phase walk");
        bits3(1'b0, 1'b0, 1'b0, "R2 phase wrap");

        // R4 then R3: two early ones, lock only at third edge
        step(1'b0, 1'b1, "R4 first one");
        step(1'b0, 1'b1, "R4 second one no lock");
        step(1'b0, 1'b0, "R3 lock at frame end");

        // R7: held while locked with activity on din
        for (int i = 0; i < 10; i++) step(1'b0, i[0], "R7 locked holds");

        // R8: reset leaves lock, first frame aligned after reset
        do_reset("R8 reset unlocks");
        bits3(1'b1, 1'b0, 1'b1, "R8 lock after reset");

        // R5: ones not carried between failing frames
        do_reset("R1 reset");
        bits3(1'b0, 1'b0, 1'b1, "R5 failing frame");
        bits3(1'b1, 1'b0, 1'b0, "R5 no carry");
        bits3(1'b1, 1'b1, 1'b1, "R3 all ones");

        // R6: alignment, 0,1,1 | 0,0,0 locks at third bit
        do_reset("R1 reset");
        bits3(1'b0, 1'b1, 1'b1, "R6 aligned lock");
        bits3(1'b0, 1'b0, 1'b0, "R6 stays locked");
        // R6: 0,0,1 | 1,0,0 straddles frames, never locks
        do_reset("R1 reset");
        bits3(1'b0, 1'b0, 1'b1, "R6 straddle a");
        bits3(1'b1, 1'b0, 1'b0, "R6 straddle b");

        // random traffic with sparse ones and occasional resets
        for (int i = 0; i < 3000; i++) begin
            bit r;
            bit b;
            r = ($urandom % 40) == 0;
            b = ($urandom % 4) == 0;
            step(r, b, "R2 R3 R5 R7 random");
        end

        finish_run();
    end
endmodule